// File: doc/BRIEF.md
# Power-up Reset Time-out Sequencer

This block produces the chip-wide internal reset after a supply power-up and after a wake-up from sleep. The power-on pulse comes in from an analog detector outside the block. When the pulse ends, the block runs up to two time-outs, one after the other. The first is a power-up delay, counted in ticks of a slow internal RC time base. The second is an oscillator start-up delay, counted in cycles of the external oscillator input. The oscillator mode chooses whether the second delay runs, and a disable bit chooses whether the first one runs. Internal reset is released only when both delays are over and the synchronized master-clear pin is high.

Only the power-on pulse starts the delays. Master clear does not start them. A board that holds master clear low until both delays are over therefore leaves reset as soon as master clear goes high, with no further wait. A wake-up event in any crystal or resonator mode restarts only the oscillator start-up delay. The power-up delay is not run again. Two done flags show how far the sequence has progressed.

Top module: `pwrup_reset_seq`

## Requirements
- R1: While `por_i` is high, every clock edge sets `rst_o` to 1 and clears `pwrt_done_o` and `ost_done_o`. Any count in progress is discarded.
- R2: With `pwrt_dis_i` = 0, `pwrt_done_o` rises on the clock edge that samples the PWRT_TICKS-th `rc_tick_i` pulse after `por_i` has fallen. Ticks sampled while `por_i` is high are not counted.
- R3: With `pwrt_dis_i` = 1, `pwrt_done_o` rises on the first clock edge that samples `por_i` low, and no RC ticks are needed.
- R4: `osc_tick_i` pulses sampled before `pwrt_done_o` is high are ignored, and `ost_done_o` is never high while `pwrt_done_o` is low.
- R5: In the modes LP (`osc_mode_i` = 1), XT (2) and HS (3), `ost_done_o` rises on the edge that samples the 1024th `osc_tick_i` pulse counted while `pwrt_done_o` is high, and not earlier.
- R6: In RC mode (`osc_mode_i` = 0), `ost_done_o` rises on the first edge after `pwrt_done_o` becomes high, with no oscillator ticks.
- R7: `rst_o` goes to 0 one clock edge after the synchronized master clear, `pwrt_done_o` and `ost_done_o` are all high. It stays 1 while any of the three is low.
- R8: `mclr_n_i` passes through a two-flop synchronizer. A change on the pin shows on `rst_o` on the third clock edge after the change. If master clear is released after both delays have expired, `rst_o` falls with only this latency.
- R9: A one-cycle `wake_i` pulse in mode LP, XT or HS clears `ost_done_o` on that edge and restarts the 1024-tick count, with reset asserted meanwhile. `pwrt_done_o` stays high.
- R10: In RC mode, `wake_i` has no effect: `ost_done_o` stays high and `rst_o` stays low.
- R11: Pulling master clear low after the delays have expired asserts `rst_o` but leaves `pwrt_done_o` and `ost_done_o` high. No delay runs again when master clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_i | input | 1 | Power-on pulse, active high. Also the synchronous reset of the block |
| mclr_n_i | input | 1 | Asynchronous master-clear pin, active low |
| wake_i | input | 1 | One-cycle wake-from-sleep event |
| osc_mode_i | input | 2 | Oscillator mode: 0 RC, 1 LP, 2 XT, 3 HS |
| pwrt_dis_i | input | 1 | 1 disables the power-up delay |
| rc_tick_i | input | 1 | One-cycle enable per internal RC time-base period |
| osc_tick_i | input | 1 | One-cycle enable per external oscillator cycle |
| rst_o | output | 1 | Internal chip reset, active high, registered |
| pwrt_done_o | output | 1 | Power-up delay finished |
| ost_done_o | output | 1 | Oscillator start-up delay finished or skipped |

## Verification
Each done flag changes on the same clock edge that samples the deciding tick, or on the edge that samples `por_i` low. In RC mode, `ost_done_o` follows `pwrt_done_o` one edge later. `rst_o` follows the last of its conditions one edge later, and a master-clear pin change shows on `rst_o` three edges after it. The bench changes its inputs on falling edges. It drives each tick for exactly one rising edge and samples on the next falling edge, so every check sits a known whole number of edges after its stimulus. The checks look at the count one pulse before the deciding tick and again on it, to show that it is exactly 1024 (or PWRT_TICKS). For master clear they look at the edge before the expected change and at the edge of the change.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    typedef enum logic [1:0] {
        OSC_RC = 2'd0,
        OSC_LP = 2'd1,
        OSC_XT = 2'd2,
        OSC_HS = 2'd3
    } osc_mode_e;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_DONE  = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic mclr_ok;
        logic pwrt_done;
        logic ost_done;
    } seq_status_t;

    // Crystal and resonator modes need the start-up wait; RC mode does not.
    function automatic logic mode_needs_ost(input osc_mode_e m);
        return m != OSC_RC;
    endfunction

    function automatic logic status_all_ok(input seq_status_t s);
        return s.mclr_ok & s.pwrt_done & s.ost_done;
    endfunction

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (clr_i) sh_q <= '0;
                else       sh_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (clr_i) sh_q <= '0;
                else       sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer
    import pwrup_seq_pkg::*;
#(
    parameter int unsigned COUNT = 1024
) (
    input  logic clk,
    input  logic clr_i,
    input  logic arm_i,
    input  logic bypass_i,
    input  logic restart_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    tmr_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (st_q != TMR_DONE && arm_i) begin
            if (bypass_i) begin
                st_d  = TMR_DONE;
                cnt_d = '0;
            end else begin
                st_d = TMR_COUNT;
                if (tick_i) begin
                    if (cnt_q == LAST) begin
                        st_d  = TMR_DONE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr_i || restart_i) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (st_q == TMR_DONE);
endmodule

// File: rtl/pwrup_reset_seq.sv
module pwrup_reset_seq
    import pwrup_seq_pkg::*;
#(
    parameter int unsigned PWRT_TICKS  = 72,
    parameter int unsigned OST_CYCLES  = 1024,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       mclr_n_i,
    input  logic       wake_i,
    input  logic [1:0] osc_mode_i,
    input  logic       pwrt_dis_i,
    input  logic       rc_tick_i,
    input  logic       osc_tick_i,
    output logic       rst_o,
    output logic       pwrt_done_o,
    output logic       ost_done_o
);
    osc_mode_e   mode;
    seq_status_t stat;
    logic        crystal;
    logic        rst_q;

    assign mode    = osc_mode_e'(osc_mode_i);
    assign crystal = mode_needs_ost(mode);

    seq_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
        .clk   (clk),
        .clr_i (por_i),
        .d_i   (mclr_n_i),
        .q_o   (stat.mclr_ok)
    );

    // Power-up delay: armed as soon as the power-on pulse is over.
    seq_tick_timer #(.COUNT(PWRT_TICKS)) u_pwrt (
        .clk       (clk),
        .clr_i     (por_i),
        .arm_i     (1'b1),
        .bypass_i  (pwrt_dis_i),
        .restart_i (1'b0),
        .tick_i    (rc_tick_i),
        .done_o    (stat.pwrt_done)
    );

    // Oscillator start-up delay: armed by the end of the power-up delay,
    // restarted by a wake event in crystal modes.
    seq_tick_timer #(.COUNT(OST_CYCLES)) u_ost (
        .clk       (clk),
        .clr_i     (por_i),
        .arm_i     (stat.pwrt_done),
        .bypass_i  (~crystal),
        .restart_i (wake_i & crystal),
        .tick_i    (osc_tick_i),
        .done_o    (stat.ost_done)
    );

    always_ff @(posedge clk) begin
        if (por_i) rst_q <= 1'b1;
        else       rst_q <= ~status_all_ok(stat);
    end

    assign rst_o       = rst_q;
    assign pwrt_done_o = stat.pwrt_done;
    assign ost_done_o  = stat.ost_done;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk
    import pwrup_seq_pkg::*;
(
    input logic       clk,
    input logic       por_i,
    input logic       mclr_n_i,
    input logic       wake_i,
    input logic [1:0] osc_mode_i,
    input logic       pwrt_dis_i,
    input logic       rc_tick_i,
    input logic       osc_tick_i,
    input logic       rst_o,
    input logic       pwrt_done_o,
    input logic       ost_done_o
);
    logic [1:0] age_q = 2'd0;
    always_ff @(posedge clk) begin
        if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    p_por_clears_r1: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        por_i |=> (rst_o && !pwrt_done_o && !ost_done_o));

    p_pwrt_needs_tick_r2: assert property (@(posedge clk) disable iff (por_i || age_q == 2'd0)
        ($rose(pwrt_done_o) && !$past(pwrt_dis_i)) |-> $past(rc_tick_i));

    p_ost_after_pwrt_r4: assert property (@(posedge clk) disable iff (por_i)
        ost_done_o |-> pwrt_done_o);

    p_ost_needs_tick_r5: assert property (@(posedge clk) disable iff (por_i || age_q == 2'd0)
        ($rose(ost_done_o) && $past(osc_mode_i) != 2'd0) |-> $past(osc_tick_i));

    p_rc_follows_pwrt_r6: assert property (@(posedge clk) disable iff (por_i || age_q == 2'd0)
        ($rose(ost_done_o) && $past(osc_mode_i) == 2'd0) |-> $past(pwrt_done_o));

    p_hold_pwrt_r7: assert property (@(posedge clk) disable iff (por_i)
        !pwrt_done_o |=> rst_o);

    p_hold_ost_r7: assert property (@(posedge clk) disable iff (por_i)
        !ost_done_o |=> rst_o);

    p_mclr_low_r8: assert property (@(posedge clk) disable iff (por_i || age_q != 2'd3)
        $past(!mclr_n_i, 3) |-> rst_o);

    p_wake_clears_r9: assert property (@(posedge clk) disable iff (por_i)
        (wake_i && osc_mode_i != 2'd0) |=> !ost_done_o);

    p_rc_wake_ignored_r10: assert property (@(posedge clk) disable iff (por_i)
        (ost_done_o && osc_mode_i == 2'd0) |=> ost_done_o);

    p_pwrt_sticky_r11: assert property (@(posedge clk) disable iff (por_i)
        pwrt_done_o |=> pwrt_done_o);
endmodule

bind pwrup_reset_seq pwrup_seq_chk u_chk (
    .clk         (clk),
    .por_i       (por_i),
    .mclr_n_i    (mclr_n_i),
    .wake_i      (wake_i),
    .osc_mode_i  (osc_mode_i),
    .pwrt_dis_i  (pwrt_dis_i),
    .rc_tick_i   (rc_tick_i),
    .osc_tick_i  (osc_tick_i),
    .rst_o       (rst_o),
    .pwrt_done_o (pwrt_done_o),
    .ost_done_o  (ost_done_o)
);

// File: tb/pwrup_reset_seq_tb.sv
module pwrup_reset_seq_tb;
    localparam int unsigned PW  = 20;
    localparam int unsigned OST = 1024;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       mclr_n_i = 1'b1;
    logic       wake_i = 1'b0;
    logic [1:0] osc_mode_i = 2'd0;
    logic       pwrt_dis_i = 1'b0;
    logic       rc_tick_i = 1'b0;
    logic       osc_tick_i = 1'b0;
    logic       rst_o, pwrt_done_o, ost_done_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwrup_reset_seq #(.PWRT_TICKS(PW), .OST_CYCLES(OST)) u_dut (
        .clk         (clk),
        .por_i       (por_i),
        .mclr_n_i    (mclr_n_i),
        .wake_i      (wake_i),
        .osc_mode_i  (osc_mode_i),
        .pwrt_dis_i  (pwrt_dis_i),
        .rc_tick_i   (rc_tick_i),
        .osc_tick_i  (osc_tick_i),
        .rst_o       (rst_o),
        .pwrt_done_o (pwrt_done_o),
        .ost_done_o  (ost_done_o)
    );

    // {mode[1:0], pwrt_dis, mclr_n}
    localparam logic [3:0] TBL [6] = '{
        {2'd0, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b1},
        {2'd2, 1'b0, 1'b1},
        {2'd1, 1'b1, 1'b1},
        {2'd3, 1'b0, 1'b1},
        {2'd1, 1'b0, 1'b0}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic osc_run(input int n, input string tag);
        for (int k = 1; k <= n; k++) begin
            osc_tick_i = 1'b1;
            cyc();
            osc_tick_i = 1'b0;
            if (k == n - 1) chk(ost_done_o, 1'b0, {tag, " one tick short"});
        end
        chk(ost_done_o, 1'b1, {tag, " on last tick"});
    endtask

    task automatic power_up(input logic [1:0] m, input logic d, input logic mc);
        por_i = 1'b1; osc_mode_i = m; pwrt_dis_i = d; mclr_n_i = mc;
        rc_tick_i = 1'b1; osc_tick_i = 1'b1; wake_i = 1'b0;
        repeat (3) cyc();
        rc_tick_i = 1'b0; osc_tick_i = 1'b0;
        chk(rst_o, 1'b1, "R1 reset during por");
        chk(pwrt_done_o, 1'b0, "R1 pwrt_done during por");
        chk(ost_done_o, 1'b0, "R1 ost_done during por");
        por_i = 1'b0;
        if (d) begin
            cyc();
            chk(pwrt_done_o, 1'b1, "R3 disabled delay done at once");
        end else begin
            for (int k = 1; k <= int'(PW); k++) begin
                rc_tick_i = 1'b1; osc_tick_i = 1'b1;
                cyc();
                rc_tick_i = 1'b0; osc_tick_i = 1'b0;
                if (k == int'(PW) - 1) chk(pwrt_done_o, 1'b0, "R2 one tick short");
            end
            chk(pwrt_done_o, 1'b1, "R2 done on last rc tick");
        end
        chk(ost_done_o, 1'b0, "R4 ost not done with pwrt");
        if (m == 2'd0) begin
            cyc();
            chk(ost_done_o, 1'b1, "R6 rc mode skips ost");
            chk(rst_o, 1'b1, "R7 reset one edge after dones");
            cyc();
            chk(rst_o, !mc, "R7 reset release");
        end else begin
            osc_run(OST, "R5 ost 1024 ticks");
            chk(rst_o, 1'b1, "R7 reset still held");
            cyc();
            chk(rst_o, !mc, "R7 R8 reset release");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cyc();
        for (int r = 0; r < 6; r++) begin
            power_up(TBL[r][3:2], TBL[r][1], TBL[r][0]);
        end

        // R8: master clear held low past both expiries, then released
        chk(pwrt_done_o, 1'b1, "R8 pwrt expired under mclr low");
        chk(ost_done_o, 1'b1, "R8 ost expired under mclr low");
        mclr_n_i = 1'b1;
        cyc(); cyc();
        chk(rst_o, 1'b1, "R8 reset two edges after release");
        cyc();
        chk(rst_o, 1'b0, "R8 reset released third edge");

        // R9: wake in LP mode restarts only the oscillator delay
        wake_i = 1'b1;
        cyc();
        wake_i = 1'b0;
        chk(ost_done_o, 1'b0, "R9 wake clears ost_done");
        chk(pwrt_done_o, 1'b1, "R9 pwrt_done kept");
        cyc();
        chk(rst_o, 1'b1, "R9 reset during restarted delay");
        osc_run(OST, "R9 R5 restarted count");
        cyc();
        chk(rst_o, 1'b0, "R9 reset released after restart");

        // R11: master clear mid-run, no timers rerun
        mclr_n_i = 1'b0;
        cyc(); cyc();
        chk(rst_o, 1'b0, "R8 latency before assert");
        cyc();
        chk(rst_o, 1'b1, "R11 mclr low asserts reset");
        chk(pwrt_done_o, 1'b1, "R11 pwrt_done unchanged");
        chk(ost_done_o, 1'b1, "R11 ost_done unchanged");
        mclr_n_i = 1'b1;
        cyc(); cyc();
        chk(rst_o, 1'b1, "R11 reset two edges after release");
        cyc();
        chk(rst_o, 1'b0, "R11 release with no new delay");

        // R10: wake ignored in RC mode
        power_up(2'd0, 1'b1, 1'b1);
        wake_i = 1'b1;
        cyc();
        wake_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(ost_done_o, 1'b1, "R10 rc wake keeps ost_done");
            chk(rst_o, 1'b0, "R10 rc wake keeps reset low");
            cyc();
        end

        finish_run();
    end
endmodule